// File: doc/BRIEF.md
# Vertical Sync Period Meter

This block measures the spacing of vertical sync pulses. It counts ticks of a slow timebase between one rising edge of VSYNC and the next. At each new edge it copies the finished count into a 13-bit register that software can read. A running count that reaches the top of its range sticks there and raises an overflow flag. The flag stays up until software reads the register.

The timebase tick arrives as a single-cycle strobe on `tick_i`. It normally comes from a prescaler elsewhere in the chip, set to roughly 122 kHz. At that rate a 15 Hz frame gives about 8100 ticks, which still fits in 13 bits, and a 127 Hz frame gives about 960 ticks. VSYNC is asynchronous to the clock, so it passes through two flops before its rising edge is detected. Two readings of the same input can therefore differ by one count.

Top module: `vsync_period_meter`

## Requirements
- R1: After reset, `period_o` is 0, `valid_o` is 0 and `ovf_o` is 0.
- R2: The first rising VSYNC edge after reset only starts the count. It leaves `period_o` at 0 and `valid_o` at 0.
- R3: At each later rising edge, `period_o` takes the number of `tick_i` strobes seen since the previous rising edge, within ±1, and `valid_o` becomes 1.
- R4: `period_o` changes only in the cycle after a detected edge and holds its value between edges.
- R5: When the running count reaches 8191 (all 13 bits set) before the next edge, it stays at 8191, `ovf_o` goes to 1, and the next capture gives 8191. A period of 8000 ticks leaves `ovf_o` at 0.
- R6: A one-cycle pulse on `rd_i` clears `ovf_o` on the next clock and leaves `period_o` unchanged. If an overflow is being set in the same cycle, the set wins.
- R7: Falling VSYNC edges have no effect. The measured value does not depend on the width of the high pulse.
- R8: After an overflowed period, the counter restarts from 0 at the edge. The following period is measured correctly.
- R9: A rising edge on `vsync_i` shows on `period_o` three clocks later: two clocks to synchronise the input and one to capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle timebase strobe |
| vsync_i | input | 1 | Vertical sync, asynchronous, active high |
| rd_i | input | 1 | One-cycle strobe marking a software read of the period register |
| period_o | output | 13 | Last captured period, in ticks |
| valid_o | output | 1 | At least one full period has been captured |
| ovf_o | output | 1 | A running count saturated; cleared by `rd_i` |

## Verification
The assertions assume that `tick_i` and `rd_i` are single-cycle strobes sampled on the clock. They also assume that VSYNC stays at each level for at least a few clocks, so the synchroniser never swallows a pulse. The bench drives every input on the falling clock edge. It makes ticks with a free-running divide-by-4 counter and holds each VSYNC level for at least four clocks. Expected counts therefore follow from the number of clocks between rising edges divided by four, and the ±1 band covers the phase of the tick against the edge.

// File: rtl/vsp_pkg.sv
package vsp_pkg;

  // Saturating increment: stays at lim once reached.
  function automatic int unsigned sat_step(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // True when one more step would land exactly on the limit.
  function automatic logic hits_limit(input int unsigned v, input int unsigned lim);
    return (v + 1) == lim;
  endfunction

endpackage

// File: rtl/vsp_edge_sync.sv
module vsp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R7
  edge_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/vsp_period_cnt.sv
module vsp_period_cnt
  import vsp_pkg::*;
#(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         edge_i,
  output logic [W-1:0] count_o,
  output logic         armed_o,
  output logic         sat_evt_o
);
  localparam logic [W-1:0] CNT_MAX = '1;
  localparam int unsigned  LIM     = (1 << W) - 1;

  logic [W-1:0] cnt_q;
  logic         armed_q;
  logic         step_w;

  assign step_w    = armed_q & tick_i & ~edge_i;
  assign sat_evt_o = step_w & hits_limit(int'(cnt_q), LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (edge_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (step_w) begin
        cnt_q <= W'(sat_step(int'(cnt_q), LIM));
      end
    end
  end

  assign count_o = cnt_q;
  assign armed_o = armed_q;

  // R3
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> (cnt_q == '0));

  // R5
  saturate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && tick_i && !edge_i) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/vsp_capture.sv
module vsp_capture #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         edge_i,
  input  logic         armed_i,
  input  logic [W-1:0] count_i,
  input  logic         sat_evt_i,
  input  logic         rd_i,
  output logic [W-1:0] period_o,
  output logic         valid_o,
  output logic         ovf_o
);
  logic [W-1:0] period_q;
  logic         valid_q;
  logic         ovf_q;
  logic         take_w;

  assign take_w = edge_i & armed_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      valid_q  <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      if (take_w) begin
        period_q <= count_i;
        valid_q  <= 1'b1;
      end
      if (sat_evt_i)  ovf_q <= 1'b1;
      else if (rd_i)  ovf_q <= 1'b0;
    end
  end

  assign period_o = period_q;
  assign valid_o  = valid_q;
  assign ovf_o    = ovf_q;

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_i |=> $stable(period_q));

  // R2
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(edge_i));

  // R5
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_evt_i |=> ovf_q);

  // R6
  ovf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !sat_evt_i) |=> !ovf_q);

endmodule

// File: rtl/vsync_period_meter.sv
module vsync_period_meter #(
  parameter int W          = 13,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         vsync_i,
  input  logic         rd_i,
  output logic [W-1:0] period_o,
  output logic         valid_o,
  output logic         ovf_o
);
  logic         vs_rise_w;
  logic [W-1:0] run_cnt_w;
  logic         armed_w;
  logic         sat_evt_w;

  vsp_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (vsync_i),
    .rise_o  (vs_rise_w)
  );

  vsp_period_cnt #(.W(W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .edge_i    (vs_rise_w),
    .count_o   (run_cnt_w),
    .armed_o   (armed_w),
    .sat_evt_o (sat_evt_w)
  );

  vsp_capture #(.W(W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .edge_i    (vs_rise_w),
    .armed_i   (armed_w),
    .count_i   (run_cnt_w),
    .sat_evt_i (sat_evt_w),
    .rd_i      (rd_i),
    .period_o  (period_o),
    .valid_o   (valid_o),
    .ovf_o     (ovf_o)
  );

  // R8
  rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_rise_w && armed_w) |=> (run_cnt_w == '0 && valid_o));

endmodule

// File: tb/vsync_period_meter_tb.sv
module vsync_period_meter_tb_top;
  localparam int W    = 13;
  localparam int DIV  = 4;
  localparam int VMAX = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tick_i = 1'b0;
  logic         vsync_i = 1'b0;
  logic         rd_i = 1'b0;
  logic [W-1:0] period_o;
  logic         valid_o;
  logic         ovf_o;

  int n_chk = 0;
  int n_bad = 0;
  int prev_n = 0;
  bit have_prev = 1'b0;
  int tdiv = 0;

  always #2.5 clk = ~clk;

  vsync_period_meter #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .vsync_i(vsync_i),
    .rd_i(rd_i), .period_o(period_o), .valid_o(valid_o), .ovf_o(ovf_o)
  );

  always @(negedge clk) begin
    tdiv   = (tdiv == DIV - 1) ? 0 : tdiv + 1;
    tick_i <= (tdiv == DIV - 1);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expect_ticks(input int clks);
    int t = clks / DIV;
    return (t > VMAX) ? VMAX : t;
  endfunction

  function automatic bit near(input int a, input int e);
    return (a >= e - 1) && (a <= e + 1);
  endfunction

  // One frame of n clocks with the sync high for hi clocks (hi >= 4).
  task automatic frame(input int n, input int hi, input string req);
    int old = int'(period_o);
    int e;
    vsync_i = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(int'(period_o) == old, "R9 no change before third clock", int'(period_o), old);
    @(negedge clk);
    if (!have_prev) begin
      chk(period_o == '0 && !valid_o, "R2 first edge only arms", int'(period_o), 0);
    end else begin
      e = expect_ticks(prev_n);
      chk(near(int'(period_o), e) && valid_o, req, int'(period_o), e);
    end
    old = int'(period_o);
    for (int k = 3; k < n; k++) begin
      if (k >= hi) vsync_i = 1'b0;
      @(negedge clk);
    end
    vsync_i = 1'b0;
    chk(int'(period_o) == old, "R4 held between edges", int'(period_o), old);
    prev_n = n;
    have_prev = 1'b1;
  endtask

  task automatic t_reset();
    chk(period_o == '0, "R1 period", int'(period_o), 0);
    chk(!valid_o, "R1 valid", int'(valid_o), 0);
    chk(!ovf_o, "R1 ovf", int'(ovf_o), 0);
  endtask

  task automatic t_basic();
    frame(400, 20, "R2 arm");
    frame(400, 20, "R3 first period");
    frame(800, 700, "R3 period 400");
    frame(1200, 5, "R7 wide pulse ignored");
    frame(32000, 10, "R3 period 1200 narrow pulse");
  endtask

  task automatic t_overflow();
    int held;
    frame(33400, 40, "R5 8000 ticks no overflow");
    chk(ovf_o, "R5 overflow flag", int'(ovf_o), 1);
    frame(600, 30, "R5 saturated capture");
    chk(int'(period_o) == VMAX, "R5 exact max", int'(period_o), VMAX);
    held = int'(period_o);
    rd_i = 1'b1; @(negedge clk); rd_i = 1'b0;
    chk(!ovf_o, "R6 read clears overflow", int'(ovf_o), 0);
    chk(int'(period_o) == held, "R6 read keeps period", int'(period_o), held);
    rd_i = 1'b1; @(negedge clk); rd_i = 1'b0;
    chk(int'(period_o) == held && !ovf_o, "R6 idle read no effect", int'(period_o), held);
    frame(400, 30, "R8 period after overflow");
    chk(!ovf_o, "R8 no new overflow", int'(ovf_o), 0);
    frame(400, 30, "R3 period 400 again");
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_overflow();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule